// File: doc/BRIEF.md
# Task-Tagged Address Translation Buffer with Variable Pages

This block is the translation buffer of a memory management unit. It holds a small, fully associative set of entries that software loads one at a time through an indexed write port. Each lookup presents a 32-bit virtual address, an 8-bit task identifier, an access kind and a supervisor flag. The buffer returns the physical address, or the reason the access cannot go ahead. Each entry maps one page whose size is chosen per entry, from 4 KB up to 16 MB in factors of four. The entry grants or withholds write and execute rights, and it may be restricted to supervisor mode.

The buffer never walks page tables. A lookup that finds no entry reports a miss, and a lookup that breaks a permission reports a protection or supervisor fault. Either report arrives on the response of that same lookup, so the pipeline can raise a precise exception and software can refill or repair the entry. The number of lookup ports is a parameter. The default of two serves a data side that issues two accesses per cycle. A global invalidate input empties the whole buffer in one cycle, for example on a change of address space.

Top module: `xtlb`

## Requirements
- R1: A synchronous active-low reset clears every entry, and each response port then shows rsp_valid 0, rsp_hit 0, rsp_fault 00 and rsp_pa 0.
- R2: A lookup presented with lk_valid high in cycle k is answered on the response ports in cycle k+1. In a cycle after lk_valid was low, rsp_valid is 0 and rsp_hit, rsp_fault and rsp_pa are all zero.
- R3: An entry matches only when three conditions hold. It is valid, its task ID equals the requesting task ID, and the virtual address bits at and above the entry's page boundary equal its stored tag.
- R4: The 3-bit page size code s, from 0 to 6, lets the low 12+2s address bits pass through untranslated, which gives 4K, 16K, 64K, 256K, 1M, 4M and 16M pages. Code 7 behaves as code 6. The physical address is the stored frame bits above the boundary joined to the virtual address bits below it.
- R5: Fault codes on rsp_fault are 00 none, 01 miss, 10 protection and 11 supervisor violation. When no entry matches, the fault is 01, and this outranks every other fault.
- R6: A matching entry that is marked supervisor-only gives fault 11 when lk_super is 0. This outranks a write or execute violation.
- R7: Access kind is coded 00 read, 01 write and 10 execute. A write to an entry without write permission, or an execute from an entry without execute permission, gives fault 10, and a read is always permitted. On any fault, rsp_hit is 0 and rsp_pa is 0.
- R8: When several entries match, the entry with the lowest index supplies the translation and the permissions.
- R9: All lookup ports translate independently in the same cycle.
- R10: An entry write in cycle k is seen by lookups from cycle k+1 onwards. A lookup in cycle k itself sees the old contents.
- R11: Writing an entry with wr_valid 0 removes that entry from matching.
- R12: A high inval clears all entries in one cycle. It wins over an entry write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| inval | input | 1 | Clear all entries |
| wr_en | input | 1 | Write one entry |
| wr_idx | input | IDX_W (4) | Entry index to write |
| wr_valid | input | 1 | Valid bit for the written entry |
| wr_task | input | 8 | Task ID of the entry |
| wr_vtag | input | 20 | Virtual address bits 31:12 |
| wr_ptag | input | 20 | Physical address bits 31:12 |
| wr_size | input | 3 | Page size code |
| wr_can_w | input | 1 | Write permitted |
| wr_can_x | input | 1 | Execute permitted |
| wr_sup | input | 1 | Supervisor-only entry |
| lk_valid | input | NPORT | Lookup request per port |
| lk_va | input | NPORT x 32 | Virtual address per port |
| lk_task | input | NPORT x 8 | Requesting task ID per port |
| lk_kind | input | NPORT x 2 | Access kind per port |
| lk_super | input | NPORT | Requester in supervisor mode |
| rsp_valid | output | NPORT | Response present |
| rsp_hit | output | NPORT | Translation granted |
| rsp_fault | output | NPORT x 2 | Fault cause |
| rsp_pa | output | NPORT x 32 | Physical address |

## Verification
Every lookup result is due exactly one clock after it is presented. Entry writes and invalidates apply at the edge that ends their cycle, so they affect lookups presented in the next cycle. The bench drives inputs at the falling edge, holds them through one rising edge and reads the response at the following falling edge, which is the single cycle the result is registered in. For R10, a write and a lookup share one cycle and the old contents are expected. The same lookup one cycle later must then see the new entry.

// File: rtl/xtlb_pkg.sv
// Package: shared widths, codes and the entry record for the translation buffer.
// Assumes 32-bit addresses, a 4 KB smallest page and page sizes stepping by 4x.
package xtlb_pkg;
    localparam int unsigned VA_W     = 32;
    localparam int unsigned PAGE_LSB = 12;
    localparam int unsigned TAG_W    = VA_W - PAGE_LSB;
    localparam int unsigned TASK_W   = 8;
    localparam int unsigned SZ_W     = 3;
    localparam int unsigned SZ_MAX   = 6;
    localparam int unsigned SZ_STEP  = 2;

    localparam logic [1:0] ACC_READ  = 2'b00;
    localparam logic [1:0] ACC_WRITE = 2'b01;
    localparam logic [1:0] ACC_EXEC  = 2'b10;

    typedef enum logic [1:0] {
        FLT_NONE  = 2'b00,
        FLT_MISS  = 2'b01,
        FLT_PROT  = 2'b10,
        FLT_SUPER = 2'b11
    } fault_t;

    typedef struct packed {
        logic              valid;
        logic [TASK_W-1:0] task_id;
        logic [TAG_W-1:0]  vtag;
        logic [TAG_W-1:0]  ptag;
        logic [SZ_W-1:0]   size;
        logic              can_w;
        logic              can_x;
        logic              sup_only;
    } entry_t;

    // Mask of tag bits that take part in matching for a size code (code 7 clamps to 6).
    function automatic logic [TAG_W-1:0] page_keep(input logic [SZ_W-1:0] code);
        int unsigned s;
        logic [TAG_W-1:0] m;
        if (code > SZ_W'(SZ_MAX)) s = SZ_MAX;
        else                      s = 32'(code);
        for (int j = 0; j < int'(TAG_W); j++) m[j] = (32'(j) >= SZ_STEP * s);
        return m;
    endfunction
endpackage

// File: rtl/xtlb_store.sv
// Module: entry storage. Holds ENTRIES records, written one per cycle by index.
// Assumes the writer keeps wr_idx below ENTRIES; inval wins over a same-cycle write.
module xtlb_store
    import xtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      inval,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  entry_t                    wr_entry,
    output entry_t [ENTRIES-1:0]      ents
);
    entry_t [ENTRIES-1:0] ents_q;

    // Update: reset, global invalidate, or single indexed write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ents_q <= '0;
        end else if (inval) begin
            for (int e = 0; e < int'(ENTRIES); e++) ents_q[e].valid <= 1'b0;
        end else if (wr_en) begin
            ents_q[wr_idx] <= wr_entry;
        end
    end

    assign ents = ents_q;

    // R12: invalidate leaves no valid entry
    a_r12_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
        inval |=> (ents_q[0].valid == 1'b0) && (ents_q[ENTRIES-1].valid == 1'b0));

    // R10: an accepted write is stored for the next cycle
    a_r10_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !inval) |=> ents_q[$past(wr_idx)] == $past(wr_entry));
endmodule

// File: rtl/xtlb_port.sv
// Module: one lookup port. Compares the request against every entry, picks the
// lowest matching index, checks rights and registers the response for one cycle.
// Assumes entries come straight from the store (writes seen the cycle after).
module xtlb_port
    import xtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  entry_t [ENTRIES-1:0]  ents,
    input  logic                  lk_valid,
    input  logic [VA_W-1:0]       lk_va,
    input  logic [TASK_W-1:0]     lk_task,
    input  logic [1:0]            lk_kind,
    input  logic                  lk_super,
    output logic                  rsp_valid,
    output logic                  rsp_hit,
    output logic [1:0]            rsp_fault,
    output logic [VA_W-1:0]       rsp_pa
);
    logic [ENTRIES-1:0] hit_vec;
    logic [IDX_W-1:0]   sel;
    logic               found;
    entry_t             chosen;
    fault_t             flt_c;
    logic [TAG_W-1:0]   keep_c;
    logic [VA_W-1:0]    pa_c;

    // Per-entry comparator: valid, same task, equal tag above the page boundary.
    for (genvar e = 0; e < int'(ENTRIES); e++) begin : g_cmp
        always_comb begin
            hit_vec[e] = ents[e].valid && (ents[e].task_id == lk_task) &&
                (((ents[e].vtag ^ lk_va[VA_W-1:PAGE_LSB]) & page_keep(ents[e].size)) == '0);
        end
    end

    // Priority pick: lowest matching index wins.
    always_comb begin
        sel   = '0;
        found = 1'b0;
        for (int e = int'(ENTRIES) - 1; e >= 0; e--) begin
            if (hit_vec[e]) begin
                sel   = IDX_W'(e);
                found = 1'b1;
            end
        end
    end

    assign chosen = ents[sel];

    // Fault ranking: miss, then supervisor, then write/execute rights.
    always_comb begin
        if (!found)                                        flt_c = FLT_MISS;
        else if (chosen.sup_only && !lk_super)             flt_c = FLT_SUPER;
        else if ((lk_kind == ACC_WRITE && !chosen.can_w) ||
                 (lk_kind == ACC_EXEC  && !chosen.can_x))  flt_c = FLT_PROT;
        else                                               flt_c = FLT_NONE;
    end

    // Address forming: frame bits above the boundary, offset bits below it.
    always_comb begin
        keep_c = page_keep(chosen.size);
        pa_c   = {(chosen.ptag & keep_c) | (lk_va[VA_W-1:PAGE_LSB] & ~keep_c),
                  lk_va[PAGE_LSB-1:0]};
    end

    // Response register: one cycle after the request, zeros when idle or faulted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_pa    <= '0;
        end else begin
            rsp_valid <= lk_valid;
            if (lk_valid) begin
                rsp_fault <= flt_c;
                rsp_hit   <= (flt_c == FLT_NONE);
                rsp_pa    <= (flt_c == FLT_NONE) ? pa_c : '0;
            end else begin
                rsp_fault <= FLT_NONE;
                rsp_hit   <= 1'b0;
                rsp_pa    <= '0;
            end
        end
    end

    // R2: an idle cycle leaves the response quiet
    a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_hit && rsp_fault == FLT_NONE && rsp_pa == '0));

    // R7: any fault withholds the hit and the address
    a_r7_fault_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault != FLT_NONE) |-> (!rsp_hit && rsp_pa == '0));

    // R8: the chosen entry matches and no lower one does
    a_r8_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (hit_vec[sel] && ((hit_vec & ((ENTRIES'(1) << sel) - ENTRIES'(1))) == '0)));

    // R5: a request with no matching entry reports a miss next cycle
    a_r5_miss_reported: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_valid && hit_vec == '0) |=> (rsp_fault == FLT_MISS));
endmodule

// File: rtl/xtlb.sv
// Module: top of the translation buffer. One shared entry store feeds NPORT
// independent lookup ports. Assumes software performs all refills.
module xtlb
    import xtlb_pkg::*;
#(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned NPORT   = 2,
    localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        inval,
    input  logic                        wr_en,
    input  logic [IDX_W-1:0]            wr_idx,
    input  logic                        wr_valid,
    input  logic [7:0]                  wr_task,
    input  logic [19:0]                 wr_vtag,
    input  logic [19:0]                 wr_ptag,
    input  logic [2:0]                  wr_size,
    input  logic                        wr_can_w,
    input  logic                        wr_can_x,
    input  logic                        wr_sup,
    input  logic [NPORT-1:0]            lk_valid,
    input  logic [NPORT-1:0][31:0]      lk_va,
    input  logic [NPORT-1:0][7:0]       lk_task,
    input  logic [NPORT-1:0][1:0]       lk_kind,
    input  logic [NPORT-1:0]            lk_super,
    output logic [NPORT-1:0]            rsp_valid,
    output logic [NPORT-1:0]            rsp_hit,
    output logic [NPORT-1:0][1:0]       rsp_fault,
    output logic [NPORT-1:0][31:0]      rsp_pa
);
    entry_t               wr_entry;
    entry_t [ENTRIES-1:0] ents;

    // Gather the write fields into one entry record.
    always_comb begin
        wr_entry.valid    = wr_valid;
        wr_entry.task_id  = wr_task;
        wr_entry.vtag     = wr_vtag;
        wr_entry.ptag     = wr_ptag;
        wr_entry.size     = wr_size;
        wr_entry.can_w    = wr_can_w;
        wr_entry.can_x    = wr_can_x;
        wr_entry.sup_only = wr_sup;
    end

    xtlb_store #(.ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n), .inval(inval), .wr_en(wr_en),
        .wr_idx(wr_idx), .wr_entry(wr_entry), .ents(ents)
    );

    for (genvar p = 0; p < int'(NPORT); p++) begin : g_port
        xtlb_port #(.ENTRIES(ENTRIES)) u_port (
            .clk(clk), .rst_n(rst_n), .ents(ents),
            .lk_valid(lk_valid[p]), .lk_va(lk_va[p]), .lk_task(lk_task[p]),
            .lk_kind(lk_kind[p]), .lk_super(lk_super[p]),
            .rsp_valid(rsp_valid[p]), .rsp_hit(rsp_hit[p]),
            .rsp_fault(rsp_fault[p]), .rsp_pa(rsp_pa[p])
        );
    end
endmodule

// File: tb/xtlb_test.sv
// Bench: directed scenarios, each task checking its own results.
module xtlb_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic inval = 1'b0, wr_en = 1'b0, wr_valid = 1'b0;
    logic [3:0] wr_idx = '0;
    logic [7:0] wr_task = '0;
    logic [19:0] wr_vtag = '0, wr_ptag = '0;
    logic [2:0] wr_size = '0;
    logic wr_can_w = 1'b0, wr_can_x = 1'b0, wr_sup = 1'b0;
    logic [1:0] lk_valid = '0, lk_super = '0;
    logic [1:0][31:0] lk_va = '0;
    logic [1:0][7:0] lk_task = '0;
    logic [1:0][1:0] lk_kind = '0;
    logic [1:0] rsp_valid, rsp_hit;
    logic [1:0][1:0] rsp_fault;
    logic [1:0][31:0] rsp_pa;
    int n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    xtlb uut (
        .clk(clk), .rst_n(rst_n), .inval(inval), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_valid(wr_valid), .wr_task(wr_task), .wr_vtag(wr_vtag), .wr_ptag(wr_ptag),
        .wr_size(wr_size), .wr_can_w(wr_can_w), .wr_can_x(wr_can_x), .wr_sup(wr_sup),
        .lk_valid(lk_valid), .lk_va(lk_va), .lk_task(lk_task), .lk_kind(lk_kind),
        .lk_super(lk_super), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_fault(rsp_fault), .rsp_pa(rsp_pa)
    );

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s: got %h expected %h", what, got, exp);
        end
    endtask

    // Check port p's full response: hit, fault, PA.
    task automatic chk_rsp(input string what, input int p, input logic hit,
                           input logic [1:0] flt, input logic [31:0] pa);
        chk({what, " valid"}, 32'(rsp_valid[p]), 32'd1);
        chk({what, " hit"},   32'(rsp_hit[p]), 32'(hit));
        chk({what, " fault"}, 32'(rsp_fault[p]), 32'(flt));
        chk({what, " pa"},    rsp_pa[p], pa);
    endtask

    // Writes one entry; starts and ends at a falling edge.
    task automatic put(input int idx, input logic v, input logic [7:0] tk,
                       input logic [19:0] vt, input logic [19:0] pt, input logic [2:0] sz,
                       input logic w, input logic x, input logic s);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_valid = v; wr_task = tk; wr_vtag = vt;
        wr_ptag = pt; wr_size = sz; wr_can_w = w; wr_can_x = x; wr_sup = s;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Drives a lookup for one cycle on port p; response readable on return.
    task automatic look(input int p, input logic [31:0] va, input logic [7:0] tk,
                        input logic [1:0] kind, input logic sup);
        lk_valid[p] = 1'b1; lk_va[p] = va; lk_task[p] = tk;
        lk_kind[p] = kind; lk_super[p] = sup;
        @(negedge clk);
        lk_valid[p] = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 valid0", 32'(rsp_valid), 32'd0);
        chk("R1 hit0", 32'(rsp_hit), 32'd0);
        chk("R1 fault0", 32'(rsp_fault), 32'd0);
        look(0, 32'h1234_5678, 8'd5, 2'b00, 1'b0);
        chk_rsp("R1 R5 empty miss", 0, 1'b0, 2'b01, 32'h0);
    endtask

    task automatic t_translate();
        put(0, 1, 8'd5, 20'h12345, 20'hABCDE, 3'd0, 1, 1, 0);
        look(0, 32'h1234_5678, 8'd5, 2'b00, 1'b0);
        chk_rsp("R3 4K hit", 0, 1'b1, 2'b00, 32'hABCD_E678);
        look(0, 32'h1234_5678, 8'd6, 2'b00, 1'b0);
        chk_rsp("R3 task mismatch", 0, 1'b0, 2'b01, 32'h0);
        put(1, 1, 8'd5, 20'h44000, 20'h88000, 3'd6, 1, 1, 0);
        look(0, 32'h44AB_CDEF, 8'd5, 2'b00, 1'b0);
        chk_rsp("R4 16M", 0, 1'b1, 2'b00, 32'h88AB_CDEF);
        put(2, 1, 8'd5, 20'h30000, 20'h5A5A3, 3'd2, 1, 1, 0);
        look(0, 32'h3000_BEEF, 8'd5, 2'b00, 1'b0);
        chk_rsp("R4 64K", 0, 1'b1, 2'b00, 32'h5A5A_BEEF);
        look(0, 32'h3001_BEEF, 8'd5, 2'b00, 1'b0);
        chk_rsp("R4 64K next page miss", 0, 1'b0, 2'b01, 32'h0);
        put(5, 1, 8'd5, 20'h66000, 20'h22000, 3'd7, 1, 1, 0);
        look(0, 32'h6612_3456, 8'd5, 2'b00, 1'b0);
        chk_rsp("R4 code7 as 16M", 0, 1'b1, 2'b00, 32'h2212_3456);
    endtask

    task automatic t_rights();
        put(3, 1, 8'd9, 20'h70000, 20'h11111, 3'd0, 0, 0, 0);
        look(0, 32'h7000_0010, 8'd9, 2'b01, 1'b0);
        chk_rsp("R7 write denied", 0, 1'b0, 2'b10, 32'h0);
        look(0, 32'h7000_0010, 8'd9, 2'b10, 1'b0);
        chk_rsp("R7 exec denied", 0, 1'b0, 2'b10, 32'h0);
        look(0, 32'h7000_0010, 8'd9, 2'b00, 1'b0);
        chk_rsp("R7 read allowed", 0, 1'b1, 2'b00, 32'h1111_1010);
        put(4, 1, 8'd9, 20'h80000, 20'h22222, 3'd0, 0, 1, 1);
        look(0, 32'h8000_0004, 8'd9, 2'b00, 1'b0);
        chk_rsp("R6 user read", 0, 1'b0, 2'b11, 32'h0);
        look(0, 32'h8000_0004, 8'd9, 2'b01, 1'b0);
        chk_rsp("R6 outranks write", 0, 1'b0, 2'b11, 32'h0);
        look(0, 32'h8000_0004, 8'd9, 2'b00, 1'b1);
        chk_rsp("R6 super read", 0, 1'b1, 2'b00, 32'h2222_2004);
        look(0, 32'h8000_0004, 8'd9, 2'b01, 1'b1);
        chk_rsp("R7 super write denied", 0, 1'b0, 2'b10, 32'h0);
        look(0, 32'h8000_0004, 8'd8, 2'b01, 1'b0);
        chk_rsp("R5 miss outranks", 0, 1'b0, 2'b01, 32'h0);
    endtask

    task automatic t_priority();
        put(6, 1, 8'd3, 20'h90000, 20'hAAAAA, 3'd0, 1, 1, 0);
        put(7, 1, 8'd3, 20'h90000, 20'hBBBBB, 3'd0, 1, 1, 0);
        look(0, 32'h9000_0100, 8'd3, 2'b00, 1'b0);
        chk_rsp("R8 lowest index", 0, 1'b1, 2'b00, 32'hAAAA_A100);
        put(6, 0, 8'd3, 20'h90000, 20'hAAAAA, 3'd0, 1, 1, 0);
        look(0, 32'h9000_0100, 8'd3, 2'b00, 1'b0);
        chk_rsp("R11 cleared entry", 0, 1'b1, 2'b00, 32'hBBBB_B100);
    endtask

    task automatic t_dual();
        lk_valid[1] = 1'b1; lk_va[1] = 32'h44AB_0001; lk_task[1] = 8'd5;
        lk_kind[1] = 2'b00; lk_super[1] = 1'b0;
        look(0, 32'h1234_5ABC, 8'd5, 2'b00, 1'b0);
        lk_valid[1] = 1'b0;
        chk_rsp("R9 port0", 0, 1'b1, 2'b00, 32'hABCD_EABC);
        chk_rsp("R9 port1", 1, 1'b1, 2'b00, 32'h88AB_0001);
        @(negedge clk);
        chk("R2 idle valid", 32'(rsp_valid), 32'd0);
        chk("R2 idle pa", rsp_pa[0], 32'h0);
    endtask

    task automatic t_write_timing();
        wr_en = 1'b1; wr_idx = 4'd8; wr_valid = 1'b1; wr_task = 8'd1; wr_vtag = 20'hC0000;
        wr_ptag = 20'hD0000; wr_size = 3'd0; wr_can_w = 1'b1; wr_can_x = 1'b1; wr_sup = 1'b0;
        look(0, 32'hC000_0000, 8'd1, 2'b00, 1'b0);
        wr_en = 1'b0;
        chk_rsp("R10 same cycle old", 0, 1'b0, 2'b01, 32'h0);
        look(0, 32'hC000_0000, 8'd1, 2'b00, 1'b0);
        chk_rsp("R10 next cycle new", 0, 1'b1, 2'b00, 32'hD000_0000);
    endtask

    task automatic t_inval();
        inval = 1'b1;
        put(9, 1, 8'd5, 20'hE0000, 20'hF0000, 3'd0, 1, 1, 0);
        inval = 1'b0;
        look(0, 32'hE000_0000, 8'd5, 2'b00, 1'b0);
        chk_rsp("R12 write loses", 0, 1'b0, 2'b01, 32'h0);
        look(0, 32'h1234_5678, 8'd5, 2'b00, 1'b0);
        chk_rsp("R12 all cleared", 0, 1'b0, 2'b01, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_translate();
        t_rights();
        t_priority();
        t_dual();
        t_write_timing();
        t_inval();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        #(20 * 100000);
        n_err++;
        n_chk++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule